// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core (Instruction Subset)

This block is a compact processor that completes one instruction per clock. In each cycle it takes the word at the current program counter from an instruction read port and decodes it. It reads two operands from a 32-entry register file and computes a result in a small ALU. A load or store uses a data port with per-byte write enables. In the same cycle the core writes the result back and moves the program counter to the next instruction. Loads return in the same cycle, so the data memory behind the port must read combinationally and write on the rising clock edge.

Instructions come in three 32-bit layouts:

- Register form: a 6-bit opcode in bits 31:26, then source A in 25:21, source B in 20:16, destination in 15:11, a shift amount in 10:6 that this block ignores, and an operation selector in 5:0.
- Immediate form: opcode, source A, source/destination B, and a 16-bit constant in bits 15:0.
- Jump form: opcode and a 26-bit word target.

A debug port reads any register combinationally, and the program counter is exposed as an output. A test environment can use both to follow the architectural state.

Top module: `rcore_top`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and clears all 32 registers. This is visible on the first clock after the edge that samples reset.
- R2: Register 0 always reads as zero on every read port. Any instruction that targets it leaves every register unchanged.
- R3: Opcode 0 selects the operation by its low six bits. Selector 32 adds and selector 34 subtracts, both wrapping modulo 2^32 without any trap. Selector 42 writes 1 when source A is less than source B as signed two's-complement values, and 0 otherwise.
- R4: Several opcodes take an immediate and write the B register:
  - Opcode 8 adds the sign-extended immediate.
  - Opcode 13 ORs the zero-extended immediate.
  - Opcode 10 is a signed less-than against the sign-extended immediate.
  - Opcode 15 loads the immediate into bits 31:16 and clears bits 15:0.
- R5: Opcode 35 loads a word and opcode 43 stores one. The byte address is source A plus the sign-extended immediate, and all four byte enables are active. Byte enable bit 3 covers data bits 31:24, which is the byte at offset 0 of the word (big-endian).
- R6: Opcode 32 loads a byte and opcode 40 stores one, using the same addressing as R5.
  - The byte at offset k within a word occupies data bits 31-8k down to 24-8k.
  - A byte load sign-extends that byte.
  - A byte store raises only enable bit 3-k and repeats the low byte of register B in all four lanes.
- R7: Opcode 4 branches when the two sources are equal, and opcode 5 branches when they differ. A taken branch goes to PC+4 plus the sign-extended immediate shifted left by 2. A branch that is not taken goes to PC+4.
- R8: Opcode 2 jumps to the upper four bits of PC+4 joined with the 26-bit field shifted left by 2. Opcode 3 jumps the same way and also writes PC+4 into register 31.
- R9: Opcode 0 with selector 8 sets the program counter to the value of source A.
- R10: Any other opcode, or any other selector under opcode 0, only advances the program counter by 4. It writes no register and makes no memory request.
- R11: The debug port returns the current value of the register it selects, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_waddr | output | 30 | Word index of the instruction being fetched (PC bits 31:2) |
| imem_rdata | input | 32 | Instruction word at imem_waddr |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Store data, lane-aligned |
| dmem_be | output | 4 | Byte write enables, bit 3 = offset 0 |
| dmem_we | output | 1 | Store request this cycle |
| dmem_re | output | 1 | Load request this cycle |
| dmem_rdata | input | 32 | Combinational read data at dmem_addr |
| dbg_sel | input | 5 | Register index for the debug port |
| dbg_data | output | 32 | Value of register dbg_sel |
| pc_o | output | 32 | Current program counter |

## Verification
The embedded assertions check several properties on every cycle:

- Register 0 stays zero.
- Reset brings the program counter to 0.
- A sequential instruction advances the program counter by exactly 4.
- A byte store raises exactly one enable.
- Loads and stores are never requested together.
- A jump-and-link writes PC+4 into register 31.

Other behaviour can only be shown by running a program against the bench's behavioural model of the architecture:

- wrapping arithmetic and signed comparison;
- big-endian lane selection with sign extension on byte loads;
- branch and jump target arithmetic, including backward branches;
- the silent execution of undefined encodings.

The program covers all of these.

// File: rtl/rcore_pkg.sv
package rcore_pkg;

    localparam int XLEN   = 32;
    localparam int REG_AW = 5;
    localparam int NREGS  = 1 << REG_AW;
    localparam int IMM_W  = 16;
    localparam int JT_W   = 26;
    localparam int BYTES  = XLEN / 8;

    localparam logic [5:0] OPC_REG  = 6'd0;
    localparam logic [5:0] OPC_J    = 6'd2;
    localparam logic [5:0] OPC_JAL  = 6'd3;
    localparam logic [5:0] OPC_BEQ  = 6'd4;
    localparam logic [5:0] OPC_BNE  = 6'd5;
    localparam logic [5:0] OPC_ADDI = 6'd8;
    localparam logic [5:0] OPC_SLTI = 6'd10;
    localparam logic [5:0] OPC_ORI  = 6'd13;
    localparam logic [5:0] OPC_LUI  = 6'd15;
    localparam logic [5:0] OPC_LB   = 6'd32;
    localparam logic [5:0] OPC_LW   = 6'd35;
    localparam logic [5:0] OPC_SB   = 6'd40;
    localparam logic [5:0] OPC_SW   = 6'd43;

    localparam logic [5:0] SEL_JR  = 6'd8;
    localparam logic [5:0] SEL_ADD = 6'd32;
    localparam logic [5:0] SEL_SUB = 6'd34;
    localparam logic [5:0] SEL_SLT = 6'd42;

    localparam logic [REG_AW-1:0] LINK_REG = REG_AW'(NREGS - 1);

    typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_SLT, ALU_OR, ALU_HI} alu_op_e;
    typedef enum logic [1:0] {WB_ALU, WB_WORD, WB_BYTE, WB_LINK} wb_sel_e;
    typedef enum logic [1:0] {DST_RD, DST_RT, DST_LINK} dst_e;
    typedef enum logic [2:0] {NX_SEQ, NX_BEQ, NX_BNE, NX_JUMP, NX_JREG} next_e;

    typedef struct packed {
        logic [5:0]        opc;
        logic [REG_AW-1:0] rs;
        logic [REG_AW-1:0] rt;
        logic [REG_AW-1:0] rd;
        logic [4:0]        sh;
        logic [5:0]        sel;
    } rfmt_t;

    typedef struct packed {
        alu_op_e alu_op;
        logic    use_imm;
        logic    zext;
        logic    reg_we;
        dst_e    dst;
        wb_sel_e wb;
        logic    mem_rd;
        logic    mem_wr;
        logic    mem_byte;
        next_e   nxt;
    } ctrl_t;

    function automatic logic [BYTES-1:0] lane_enable(input logic [1:0] off);
        return {1'b1, {(BYTES-1){1'b0}}} >> off;
    endfunction

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/rcore_decode.sv
module rcore_decode
    import rcore_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctrl
);
    rfmt_t f;
    assign f = rfmt_t'(instr);

    always_comb begin
        ctrl = '0;
        case (f.opc)
            OPC_REG: begin
                ctrl.dst = DST_RD;
                case (f.sel)
                    SEL_ADD: begin ctrl.alu_op = ALU_ADD; ctrl.reg_we = 1'b1; end
                    SEL_SUB: begin ctrl.alu_op = ALU_SUB; ctrl.reg_we = 1'b1; end
                    SEL_SLT: begin ctrl.alu_op = ALU_SLT; ctrl.reg_we = 1'b1; end
                    SEL_JR:  ctrl.nxt = NX_JREG;
                    default: ;
                endcase
            end
            OPC_ADDI, OPC_SLTI, OPC_ORI, OPC_LUI: begin
                ctrl.use_imm = 1'b1;
                ctrl.reg_we  = 1'b1;
                ctrl.dst     = DST_RT;
                ctrl.zext    = (f.opc == OPC_ORI) || (f.opc == OPC_LUI);
                ctrl.alu_op  = (f.opc == OPC_ADDI) ? ALU_ADD :
                               (f.opc == OPC_SLTI) ? ALU_SLT :
                               (f.opc == OPC_ORI)  ? ALU_OR  : ALU_HI;
            end
            OPC_LW, OPC_LB: begin
                ctrl.use_imm  = 1'b1;
                ctrl.reg_we   = 1'b1;
                ctrl.dst      = DST_RT;
                ctrl.mem_rd   = 1'b1;
                ctrl.mem_byte = (f.opc == OPC_LB);
                ctrl.wb       = (f.opc == OPC_LB) ? WB_BYTE : WB_WORD;
            end
            OPC_SW, OPC_SB: begin
                ctrl.use_imm  = 1'b1;
                ctrl.mem_wr   = 1'b1;
                ctrl.mem_byte = (f.opc == OPC_SB);
            end
            OPC_BEQ: ctrl.nxt = NX_BEQ;
            OPC_BNE: ctrl.nxt = NX_BNE;
            OPC_J:   ctrl.nxt = NX_JUMP;
            OPC_JAL: begin
                ctrl.nxt    = NX_JUMP;
                ctrl.reg_we = 1'b1;
                ctrl.dst    = DST_LINK;
                ctrl.wb     = WB_LINK;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rcore_alu.sv
module rcore_alu
    import rcore_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e       op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [W-1:0]  y
);
    localparam int HALF = W / 2;

    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_OR:  y = a | b;
            ALU_HI:  y = {b[HALF-1:0], {HALF{1'b0}}};
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile #(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    output logic [DW-1:0] rd_a,
    input  logic [AW-1:0] ra_b,
    output logic [DW-1:0] rd_b,
    input  logic [AW-1:0] ra_dbg,
    output logic [DW-1:0] rd_dbg,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd
);
    localparam int N = 1 << AW;

    logic [DW-1:0] rf [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) rf[i] <= '0;
        end else if (we && (wa != '0)) begin
            rf[wa] <= wd;
        end
    end

    assign rd_a   = (ra_a   == '0) ? '0 : rf[ra_a];
    assign rd_b   = (ra_b   == '0) ? '0 : rf[ra_b];
    assign rd_dbg = (ra_dbg == '0) ? '0 : rf[ra_dbg];

    // R2
    zero_reg_chk: assert property (@(posedge clk) disable iff (rst) rf[0] == '0);

endmodule

// File: rtl/rcore_top.sv
module rcore_top
    import rcore_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output logic [29:0] imem_waddr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic [3:0]  dmem_be,
    output logic        dmem_we,
    output logic        dmem_re,
    input  logic [31:0] dmem_rdata,
    input  logic [4:0]  dbg_sel,
    output logic [31:0] dbg_data,
    output logic [31:0] pc_o
);
    logic [XLEN-1:0]   pc_q, pc_next, pc_plus4, br_target, jmp_target;
    logic [XLEN-1:0]   rs_val, rt_val, alu_b, alu_y, imm_s, imm_z;
    logic [XLEN-1:0]   ld_shift, wr_data;
    logic [REG_AW-1:0] wr_addr;
    logic              wr_en, src_eq;
    rfmt_t             f;
    ctrl_t             ctrl;

    assign f = rfmt_t'(imem_rdata);

    rcore_decode u_dec (.instr(imem_rdata), .ctrl(ctrl));

    rcore_regfile #(.DW(XLEN), .AW(REG_AW)) u_rf (
        .clk(clk), .rst(rst),
        .ra_a(f.rs), .rd_a(rs_val),
        .ra_b(f.rt), .rd_b(rt_val),
        .ra_dbg(dbg_sel), .rd_dbg(dbg_data),
        .we(wr_en), .wa(wr_addr), .wd(wr_data)
    );

    assign imm_s = sext_imm(imem_rdata[IMM_W-1:0]);
    assign imm_z = {{(XLEN-IMM_W){1'b0}}, imem_rdata[IMM_W-1:0]};
    assign alu_b = !ctrl.use_imm ? rt_val : (ctrl.zext ? imm_z : imm_s);

    rcore_alu #(.W(XLEN)) u_alu (.op(ctrl.alu_op), .a(rs_val), .b(alu_b), .y(alu_y));

    // next program counter
    assign pc_plus4   = pc_q + XLEN'(4);
    assign br_target  = pc_plus4 + {imm_s[XLEN-3:0], 2'b00};
    assign jmp_target = {pc_plus4[XLEN-1:XLEN-4], imem_rdata[JT_W-1:0], 2'b00};
    assign src_eq     = (rs_val == rt_val);

    always_comb begin
        case (ctrl.nxt)
            NX_BEQ:  pc_next = src_eq  ? br_target : pc_plus4;
            NX_BNE:  pc_next = !src_eq ? br_target : pc_plus4;
            NX_JUMP: pc_next = jmp_target;
            NX_JREG: pc_next = rs_val;
            default: pc_next = pc_plus4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    // data port
    assign dmem_addr  = alu_y;
    assign dmem_we    = ctrl.mem_wr;
    assign dmem_re    = ctrl.mem_rd;
    assign dmem_be    = ctrl.mem_byte ? lane_enable(alu_y[1:0]) : {BYTES{1'b1}};
    assign dmem_wdata = ctrl.mem_byte ? {BYTES{rt_val[7:0]}} : rt_val;
    assign ld_shift   = dmem_rdata >> {(2'd3 - alu_y[1:0]), 3'b000};

    // write-back
    always_comb begin
        case (ctrl.wb)
            WB_WORD: wr_data = dmem_rdata;
            WB_BYTE: wr_data = {{(XLEN-8){ld_shift[7]}}, ld_shift[7:0]};
            WB_LINK: wr_data = pc_plus4;
            default: wr_data = alu_y;
        endcase
        case (ctrl.dst)
            DST_RT:   wr_addr = f.rt;
            DST_LINK: wr_addr = LINK_REG;
            default:  wr_addr = f.rd;
        endcase
    end
    assign wr_en = ctrl.reg_we;

    assign imem_waddr = pc_q[XLEN-1:2];
    assign pc_o       = pc_q;

    // R1
    reset_pc_chk: assert property (@(posedge clk) rst |=> (pc_q == '0));
    // R10
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.nxt == NX_SEQ) |=> (pc_q == $past(pc_q) + XLEN'(4)));
    // R6
    byte_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (dmem_we && ctrl.mem_byte) |-> ($countones(dmem_be) == 1));
    // R5
    mem_excl_chk: assert property (@(posedge clk) disable iff (rst) !(dmem_we && dmem_re));
    // R8
    link_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.nxt == NX_JUMP && ctrl.dst == DST_LINK) |->
        (wr_en && wr_addr == LINK_REG && wr_data == pc_q + XLEN'(4)));

endmodule

// File: tb/rcore_top_test.sv
module rcore_top_test;
    localparam time CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [29:0] imem_waddr;
    logic [31:0] imem_rdata, dmem_addr, dmem_wdata, dmem_rdata, dbg_data, pc_o;
    logic [3:0]  dmem_be;
    logic        dmem_we, dmem_re;
    logic [4:0]  dbg_sel = '0;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] imem [64];
    logic [31:0] dmem [256];

    // reference state
    logic [31:0] m_reg [32];
    logic [31:0] m_mem [256];
    logic [31:0] m_pc;
    // expected effects of the current instruction
    logic [31:0] e_npc, e_val, e_saddr, e_sdata;
    logic        e_wen, e_st;
    logic [4:0]  e_idx;
    logic [3:0]  e_be;
    string       e_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    rcore_top uut (
        .clk(clk), .rst(rst),
        .imem_waddr(imem_waddr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_be(dmem_be),
        .dmem_we(dmem_we), .dmem_re(dmem_re), .dmem_rdata(dmem_rdata),
        .dbg_sel(dbg_sel), .dbg_data(dbg_data), .pc_o(pc_o)
    );

    assign imem_rdata = (imem_waddr[29:6] == '0) ? imem[imem_waddr[5:0]] : 32'h0;
    assign dmem_rdata = dmem[dmem_addr[9:2]];

    always @(posedge clk) begin
        if (dmem_we) begin
            for (int b = 0; b < 4; b++)
                if (dmem_be[b]) dmem[dmem_addr[9:2]][8*b +: 8] <= dmem_wdata[8*b +: 8];
        end
    end

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input int sel);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(sel)};
    endfunction
    function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(input int op, input int tgt);
        return {6'(op), 26'(tgt)};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pc = '0;
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
    endtask

    task automatic model_eval();
        logic [31:0] ins, se, ze, a, b, p4, ea, w;
        logic [5:0]  op, fn;
        logic [4:0]  rs, rt, rd;
        ins = imem[m_pc[7:2]];
        op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; fn = ins[5:0];
        se = {{16{ins[15]}}, ins[15:0]};
        ze = {16'h0, ins[15:0]};
        a = m_reg[rs]; b = m_reg[rt]; p4 = m_pc + 32'd4; ea = a + se;
        e_npc = p4; e_wen = 1'b0; e_st = 1'b0; e_idx = '0; e_val = '0;
        e_saddr = '0; e_sdata = '0; e_be = '0; e_tag = "R10";
        case (op)
            6'd0: case (fn)
                6'd32: begin e_wen = 1; e_idx = rd; e_val = a + b; e_tag = "R3"; end
                6'd34: begin e_wen = 1; e_idx = rd; e_val = a - b; e_tag = "R3"; end
                6'd42: begin e_wen = 1; e_idx = rd; e_val = ($signed(a) < $signed(b)) ? 1 : 0; e_tag = "R3"; end
                6'd8:  begin e_npc = a; e_tag = "R9"; end
                default: ;
            endcase
            6'd8:  begin e_wen = 1; e_idx = rt; e_val = a + se; e_tag = "R4"; end
            6'd13: begin e_wen = 1; e_idx = rt; e_val = a | ze; e_tag = "R4"; end
            6'd10: begin e_wen = 1; e_idx = rt; e_val = ($signed(a) < $signed(se)) ? 1 : 0; e_tag = "R4"; end
            6'd15: begin e_wen = 1; e_idx = rt; e_val = {ins[15:0], 16'h0}; e_tag = "R4"; end
            6'd35: begin e_wen = 1; e_idx = rt; e_val = m_mem[ea[9:2]]; e_tag = "R5"; end
            6'd43: begin e_st = 1; e_saddr = ea; e_be = 4'hF; e_sdata = b; e_tag = "R5"; end
            6'd32: begin
                w = m_mem[ea[9:2]] >> (8 * (3 - int'(ea[1:0])));
                e_wen = 1; e_idx = rt; e_val = {{24{w[7]}}, w[7:0]}; e_tag = "R6";
            end
            6'd40: begin
                e_st = 1; e_saddr = ea; e_be = 4'b1000 >> ea[1:0];
                e_sdata = {4{b[7:0]}}; e_tag = "R6";
            end
            6'd4: begin if (a == b) e_npc = p4 + (se << 2); e_tag = "R7"; end
            6'd5: begin if (a != b) e_npc = p4 + (se << 2); e_tag = "R7"; end
            6'd2: begin e_npc = {p4[31:28], ins[25:0], 2'b00}; e_tag = "R8"; end
            6'd3: begin
                e_npc = {p4[31:28], ins[25:0], 2'b00};
                e_wen = 1; e_idx = 5'd31; e_val = p4; e_tag = "R8";
            end
            default: ;
        endcase
        if (e_wen && e_idx == 0) e_tag = "R2";
    endtask

    task automatic model_commit();
        logic [31:0] w;
        if (e_wen && e_idx != 0) m_reg[e_idx] = e_val;
        if (e_st) begin
            w = m_mem[e_saddr[9:2]];
            for (int b = 0; b < 4; b++) if (e_be[b]) w[8*b +: 8] = e_sdata[8*b +: 8];
            m_mem[e_saddr[9:2]] = w;
        end
        m_pc = e_npc;
    endtask

    task automatic sweep_regs(input string tag);
        for (int i = 0; i < 32; i++) begin
            dbg_sel = 5'(i);
            #1;
            chk(dbg_data == m_reg[i], tag, $sformatf("debug read r%0d", i), dbg_data, m_reg[i]);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) imem[i] = 32'h0;
        for (int i = 0; i < 256; i++) begin dmem[i] = '0; m_mem[i] = '0; end
        imem[0]  = enc_i(8, 0, 1, 5);
        imem[1]  = enc_i(8, 0, 2, -3);
        imem[2]  = enc_r(1, 2, 3, 32);
        imem[3]  = enc_r(2, 1, 4, 34);
        imem[4]  = enc_r(2, 1, 5, 42);
        imem[5]  = enc_r(1, 2, 6, 42);
        imem[6]  = enc_i(13, 0, 7, 16'h8001);
        imem[7]  = enc_i(15, 0, 8, 16'h8000);
        imem[8]  = enc_r(8, 8, 9, 32);
        imem[9]  = enc_i(10, 2, 10, -2);
        imem[10] = enc_i(8, 1, 0, 7);
        imem[11] = enc_r(0, 1, 11, 32);
        imem[12] = enc_i(15, 0, 12, 16'h1234);
        imem[13] = enc_i(13, 12, 12, 16'h5678);
        imem[14] = enc_i(43, 0, 12, 16);
        imem[15] = enc_i(35, 0, 13, 16);
        imem[16] = enc_i(32, 0, 14, 16);
        imem[17] = enc_i(8, 0, 15, -1);
        imem[18] = enc_i(40, 0, 15, 19);
        imem[19] = enc_i(32, 0, 16, 19);
        imem[20] = enc_i(35, 0, 17, 16);
        imem[21] = enc_i(40, 0, 1, 17);
        imem[22] = enc_i(35, 0, 18, 16);
        imem[23] = enc_i(4, 1, 11, 1);
        imem[24] = enc_i(8, 0, 19, 99);
        imem[25] = enc_i(5, 1, 11, 1);
        imem[26] = enc_i(8, 0, 20, 1);
        imem[27] = enc_i(5, 1, 2, 1);
        imem[28] = enc_i(8, 0, 19, 98);
        imem[29] = enc_j(3, 32);
        imem[30] = enc_i(8, 0, 21, 3);
        imem[31] = enc_j(2, 35);
        imem[32] = enc_i(8, 0, 22, 4);
        imem[33] = enc_r(31, 0, 0, 8);
        imem[35] = 32'hFC00_0000;
        imem[36] = enc_r(1, 1, 23, 63);
        imem[37] = enc_i(8, 24, 24, 1);
        imem[38] = enc_i(10, 24, 25, 3);
        imem[39] = enc_i(5, 25, 0, -3);
        imem[40] = enc_j(2, 40);

        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pc_o == 32'h0, "R1", "pc during reset", pc_o, 32'h0);
        chk(!dmem_we, "R1", "no store during reset", {31'h0, dmem_we}, 32'h0);
        rst = 1'b0;

        for (int cyc = 0; cyc < 90; cyc++) begin
            dbg_sel = 5'(cyc % 32);
            #1;
            model_eval();
            chk(pc_o == m_pc, e_tag, "pc", pc_o, m_pc);
            chk(dbg_data == m_reg[dbg_sel], (dbg_sel == 0) ? "R2" : "R11",
                "debug register", dbg_data, m_reg[dbg_sel]);
            chk(dmem_we == e_st, e_tag, "store request", {31'h0, dmem_we}, {31'h0, e_st});
            if (e_st) begin
                chk(dmem_addr == e_saddr, e_tag, "store address", dmem_addr, e_saddr);
                chk(dmem_be == e_be, e_tag, "byte enables", {28'h0, dmem_be}, {28'h0, e_be});
                for (int b = 0; b < 4; b++)
                    if (e_be[b])
                        chk(dmem_wdata[8*b +: 8] == e_sdata[8*b +: 8], e_tag, "store lane",
                            dmem_wdata, e_sdata);
            end
            model_commit();
            @(negedge clk);
        end

        sweep_regs("R11");
        chk(m_reg[19] == 32'h0, "R7", "skipped instructions left r19", m_reg[19], 32'h0);
        chk(dmem[4] == m_mem[4], "R6", "memory word after byte stores", dmem[4], m_mem[4]);

        rst = 1'b1;
        @(negedge clk);
        model_reset();
        chk(pc_o == 32'h0, "R1", "pc after second reset", pc_o, 32'h0);
        sweep_regs("R1");
        rst = 1'b0;
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule